// File: doc/BRIEF.md
# Parallel Reed-Muller Majority-Logic Decoder

This block is a combinational hard-decision decoder for the second-order Reed-Muller code of length 32 (16 information bits, minimum distance 8). It takes a 32-bit received word and returns the corrected codeword together with the error vector that was removed. Any error pattern of weight three or less is corrected.

Bit position i of a word stands for the point of the five-dimensional binary space whose coordinates are the bits of i. Six two-dimensional subspaces, chosen so that no two share a nonzero vector, are fixed as a parameter. Each subspace splits the 32 positions into eight four-point cosets, which gives 48 cosets in all. Decoding runs in three stages. First, the parity of the received bits over every coset is formed. Second, each subspace takes the majority of its eight parities, and a coset whose parity disagrees with that majority is marked as holding an odd number of errors. Third, a position is flagged as erroneous when at least four of the six cosets through it are marked. The block has no clock and no storage, so the decoder is one shallow logic cone that can sit in any timing path that needs it.

Top module: `rm25_majority_decoder`

## Requirements
- R1: The decoder is purely combinational. Both outputs follow `rx_word` with no clock, and an all-zero input gives all-zero outputs.
- R2: A valid codeword passes unchanged, and `err_vec` is zero. Codeword bit p is the value of the message polynomial at x = p, where x_j is bit j of p. Message bit 0 is the constant term, bits 1 to 5 are x0 to x4, and bits 6 to 15 are the products x_j x_k for j<k, taken with j major and k minor.
- R3: For any codeword with a single flipped bit, `fixed_word` equals the codeword and `err_vec` has exactly that bit set.
- R4: For any codeword with two flipped bits, `fixed_word` equals the codeword and `err_vec` equals the flip pattern.
- R5: For any codeword with three flipped bits, `fixed_word` equals the codeword and `err_vec` equals the flip pattern.
- R6: For any input, including inputs with four or more errors, `fixed_word` equals `rx_word` XOR `err_vec`.
- R7: For any input, `err_vec` has at most 24 bits set. Each subspace marks at most four of its cosets, and every flagged bit needs four marks.
- R8: A word with 29 or more ones decodes to all ones, and a word with 3 or fewer ones decodes to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_word | input | 32 | Received hard-decision word, bit i at space point i |
| fixed_word | output | 32 | Corrected codeword |
| err_vec | output | 32 | Positions flipped by the decoder |

## Verification
Every single-bit error is applied at every position across several codewords. If one coset were wired to the wrong position, some position would then show an uncorrected or spurious flip. Random two- and three-error patterns go after the stage-3 threshold. A threshold of three would flag correct bits that touch three odd cosets, and a threshold of five would leave real errors in place when two other errors spoil cosets through them. Words with four to eight errors check that correction stays consistent and bounded even where decoding cannot succeed. The near-all-ones and all-zero inputs catch an inverted majority in stage 2.

// File: rtl/rm25_majority_decoder.sv
module rm25_majority_decoder #(
  parameter logic [59:0] SUBSPACE_BASIS = {5'd11, 5'd18, 5'd17, 5'd10, 5'd9, 5'd6,
                                           5'd5, 5'd16, 5'd8, 5'd4, 5'd2, 5'd1}
) (
  input  logic [31:0] rx_word,
  output logic [31:0] fixed_word,
  output logic [31:0] err_vec
);
  localparam int NPOS   = 32;
  localparam int NGRP   = 6;
  localparam int FLAG_T = 4;

  logic [NGRP*NPOS-1:0] coset_par;
  logic [NGRP*NPOS-1:0] odd_flag;
  logic [NGRP-1:0]      grp_major;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int VA = int'(SUBSPACE_BASIS[g*10 +: 5]);
    localparam int VB = int'(SUBSPACE_BASIS[g*10+5 +: 5]);
    for (genvar p = 0; p < NPOS; p++) begin : g_pos
      localparam int P1 = p ^ VA;
      localparam int P2 = p ^ VB;
      localparam int P3 = p ^ VA ^ VB;
      assign coset_par[g*NPOS+p] = rx_word[p] ^ rx_word[P1] ^ rx_word[P2] ^ rx_word[P3];
      assign odd_flag[g*NPOS+p]  = coset_par[g*NPOS+p] ^ grp_major[g];
    end
    // each coset appears four times among 32 positions: >16 means five or more of eight
    assign grp_major[g] = $countones(coset_par[g*NPOS +: NPOS]) > 16;
  end

  for (genvar p = 0; p < NPOS; p++) begin : g_bit
    logic [NGRP-1:0] marks;
    for (genvar g = 0; g < NGRP; g++) begin : g_mark
      assign marks[g] = odd_flag[g*NPOS+p];
    end
    assign err_vec[p] = $countones(marks) >= FLAG_T;
  end

  assign fixed_word = rx_word ^ err_vec;
endmodule

// File: rtl/rm25_majority_decoder_chk.sv
module rm25_majority_decoder_chk (
  input logic [31:0] rx_word,
  input logic [31:0] fixed_word,
  input logic [31:0] err_vec
);
  function automatic logic is_codeword(logic [31:0] w);
    logic [31:0] mask;
    logic        bad = 1'b0;
    for (int a = 0; a < 6; a++) begin
      for (int b = a; b < 6; b++) begin
        for (int p = 0; p < 32; p++) begin
          logic [5:0] x = {1'b1, 5'(p)};
          mask[p] = x[a] & x[b];
        end
        bad |= ^(w & mask);
      end
    end
    return !bad;
  endfunction

  always_comb begin
    if (!$isunknown(rx_word)) begin
      p_codeword_pass_r2: assert (!is_codeword(rx_word) || (err_vec == '0 && fixed_word == rx_word));
      p_consistent_r6: assert ((fixed_word ^ err_vec) == rx_word);
      p_flag_bound_r7: assert ($countones(err_vec) <= 24);
      p_near_zero_r8: assert ($countones(rx_word) > 3 || fixed_word == '0);
      p_near_ones_r8: assert ($countones(rx_word) < 29 || fixed_word == '1);
    end
  end
endmodule

bind rm25_majority_decoder rm25_majority_decoder_chk i_chk (
  .rx_word(rx_word), .fixed_word(fixed_word), .err_vec(err_vec)
);

// File: tb/test_rm25_majority_decoder.sv
module test_rm25_majority_decoder;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [31:0] rx = '0;
  logic [31:0] fx;
  logic [31:0] ev;
  int total = 0;
  int bad   = 0;

  rm25_majority_decoder i_rm25_majority_decoder (
    .rx_word(rx), .fixed_word(fx), .err_vec(ev)
  );

  function automatic logic [31:0] encode(logic [15:0] m);
    logic [31:0] c;
    for (int p = 0; p < 32; p++) begin
      logic [4:0] x = 5'(p);
      logic v = m[0];
      int k = 6;
      for (int j = 0; j < 5; j++) v ^= m[1+j] & x[j];
      for (int j = 0; j < 5; j++)
        for (int q = j + 1; q < 5; q++) begin
          v ^= m[k] & x[j] & x[q];
          k++;
        end
      c[p] = v;
    end
    return c;
  endfunction

  function automatic logic [31:0] pattern(int w);
    logic [31:0] e = '0;
    while ($countones(e) < w) e[$urandom % 32] = 1'b1;
    return e;
  endfunction

  task automatic apply(logic [31:0] v);
    @(negedge clk);
    rx = v;
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] c, e;
    void'($urandom(32'h1234_5eed));

    apply('0);                                   // R1
    chk("R1", fx, '0);
    chk("R1", ev, '0);

    for (int n = 0; n < 20; n++) begin           // R2
      c = (n == 0) ? '1 : encode(16'($urandom));
      apply(c);
      chk("R2", fx, c);
      chk("R2", ev, '0);
    end

    for (int n = 0; n < 4; n++) begin            // R3
      c = encode(16'($urandom));
      for (int p = 0; p < 32; p++) begin
        e = 32'd1 << p;
        apply(c ^ e);
        chk("R3", fx, c);
        chk("R3", ev, e);
      end
    end

    for (int n = 0; n < 200; n++) begin          // R4
      c = encode(16'($urandom));
      e = pattern(2);
      apply(c ^ e);
      chk("R4", fx, c);
      chk("R4", ev, e);
    end

    for (int n = 0; n < 300; n++) begin          // R5
      c = (n < 20) ? '0 : encode(16'($urandom));
      e = pattern(3);
      apply(c ^ e);
      chk("R5", fx, c);
      chk("R5", ev, e);
    end

    for (int n = 0; n < 100; n++) begin          // R6, R7
      c = encode(16'($urandom));
      e = pattern(4 + (n % 5));
      apply(c ^ e);
      chk("R6", fx ^ ev, c ^ e);
      chk("R7", 32'($countones(ev) <= 24), 32'd1);
    end

    for (int n = 0; n < 30; n++) begin           // R8
      e = pattern(n % 4);
      apply(~e);
      chk("R8", fx, '1);
      apply(e);
      chk("R8", fx, '0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule